// File: doc/BRIEF.md
# Prescaled Auto-Reload PWM Timer

A single timer channel that runs from the peripheral clock. An 8-bit prescaler divides the clock first. A power-of-two divider then divides it again to make a count tick. Each tick steps a down-counter by one. When the counter reaches zero it raises a one-cycle interrupt. It then either reloads from a count buffer (auto-reload) or halts at zero (one-shot). A compare value sets the duty of the PWM output, and a polarity bit can invert that output.

Software programs the channel through a small write port and a separate combinational read port. The count and compare buffers may be rewritten while the timer runs. New values take effect only at the next reload, unless a manual-update command forces them into the counter at once. The live count can be read at any time, which makes the channel usable for delay measurement while it is free-running.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset every register reads 0, `pwm_o` is 0 and `irq_o` is 0.
- R2: Address 1 holds the prescale value P in bits [7:0] and a divider code D in bits [11:8]. The tick period is (P+1)·2^min(D,4) clock cycles, so codes above 4 act as 4. Both dividers restart from zero whenever the run bit is clear.
- R3: The counter drops by one on each tick only while the run bit (address 0, bit 0) is 1. Otherwise it holds its value.
- R4: With the auto bit (address 0, bit 1) set, a tick at count 1 is an expiry. The counter loads the count buffer, so a buffer value N gives an interrupt every N ticks. `irq_o` is high for the single cycle after each expiry edge.
- R5: With the auto bit clear, the expiry takes the counter to 0. It raises `irq_o` once and then stays at 0 with no further interrupts.
- R6: Writes to the count buffer (address 2) or the compare buffer (address 3) during a run do not change the counter's current period. They are picked up at the next expiry reload.
- R7: Writing 1 to address 0 bit 2 (self-clearing) loads both buffers into the counter and compare registers on that edge. If this falls on an expiry edge, the load wins and no interrupt is issued.
- R8: `pwm_o` is (count > compare) XOR the invert bit (address 0, bit 3). A halted one-shot therefore rests at the inactive level, which is the invert bit's value.
- R9: Reads return the control bits {invert, 0, auto, run} at address 0, and the stored contents at addresses 1 to 3. Address 4 returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Expiry interrupt pulse |

## Verification
A manual-update write and a counter expiry can land on the same clock edge. The bench provokes this on a one-cycle tick by timing the command write to fall exactly on the edge where the count would pass from 1. It then expects no interrupt at that edge, the live count restarting from the new buffer value, and the next interrupt a full new period later. Every other interrupt is predicted by cycle number from the prescale, divider and buffer settings and matched in arrival order.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTB = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIVE = 3'd4;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_AUTO = 1;
  localparam int unsigned B_UPD  = 2;
  localparam int unsigned B_INV  = 3;

  typedef struct packed {
    logic inv;
    logic auto_rl;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DV_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [DV_W-1:0]  div_q, div_n;
  logic [DV_W-1:0]  mask;
  logic             pulse;

  always_comb begin
    for (int i = 0; i < DV_W; i++)
      mask[i] = (sel_i > SEL_W'(i));
  end

  assign pulse  = run_i && (pre_q >= pre_i);
  assign tick_o = pulse && ((div_q & mask) == mask);

  always_comb begin
    pre_n = pre_q;
    div_n = div_q;
    if (!run_i) begin
      pre_n = '0;
      div_n = '0;
    end else begin
      pre_n = pulse ? '0 : pre_q + 1'b1;
      if (pulse) div_n = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_n;
      div_q <= div_n;
    end
  end

  p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_i);
  p_idle_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pre_q == '0 && div_q == '0));
endmodule

// File: rtl/pwm_downcounter.sv
module pwm_downcounter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             auto_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] cntb_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n, cmp_q, cmp_n;
  logic             irq_q, irq_n;

  always_comb begin
    cnt_n = cnt_q;
    cmp_n = cmp_q;
    irq_n = 1'b0;
    if (upd_i) begin
      cnt_n = cntb_i;
      cmp_n = cmpb_i;
    end else if (tick_i && cnt_q == ONE) begin
      irq_n = 1'b1;
      if (auto_i) begin
        cnt_n = cntb_i;
        cmp_n = cmpb_i;
      end else begin
        cnt_n = '0;
      end
    end else if (tick_i && cnt_q != '0) begin
      cnt_n = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      cmp_q <= cmp_n;
      irq_q <= irq_n;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !upd_i) |=> ($stable(cnt_o) && !irq_o));
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !upd_i && cnt_o > ONE) |=> (cnt_o == $past(cnt_o) - ONE));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !upd_i && auto_i && cnt_o == ONE) |=> (irq_o && cnt_o == $past(cntb_i)));
  p_oneshot_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0 && !upd_i) |=> (cnt_o == '0 && !irq_o));
  p_manual_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> (!irq_o && cnt_o == $past(cntb_i) && cmp_o == $past(cmpb_i)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             inv_i,
  output logic             pwm_o
);
  logic above;
  assign above = (cnt_i > cmp_i);
  assign pwm_o = above ^ inv_i;
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              pwm_o,
  output logic              irq_o
);
  localparam int unsigned CLK_W = PRE_W + SEL_W;

  ctrl_t            ctrl_q, ctrl_n;
  logic [PRE_W-1:0] pre_q, pre_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic [CNT_W-1:0] cntb_q, cntb_n, cmpb_q, cmpb_n;
  logic [CNT_W-1:0] cnt, cmp;
  logic             upd, tick;
  logic             wr_ctrl, wr_clk, wr_cntb, wr_cmpb;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_clk  = wr_en && (wr_addr == A_CLK);
  assign wr_cntb = wr_en && (wr_addr == A_CNTB);
  assign wr_cmpb = wr_en && (wr_addr == A_CMPB);
  assign upd     = wr_ctrl && wr_data[B_UPD];

  always_comb begin
    ctrl_n = ctrl_q;
    pre_n  = pre_q;
    sel_n  = sel_q;
    cntb_n = cntb_q;
    cmpb_n = cmpb_q;
    if (wr_ctrl) begin
      ctrl_n.run     = wr_data[B_RUN];
      ctrl_n.auto_rl = wr_data[B_AUTO];
      ctrl_n.inv     = wr_data[B_INV];
    end
    if (wr_clk) begin
      pre_n = wr_data[PRE_W-1:0];
      sel_n = wr_data[CLK_W-1:PRE_W];
    end
    if (wr_cntb) cntb_n = wr_data;
    if (wr_cmpb) cmpb_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      sel_q  <= '0;
      cntb_q <= '0;
      cmpb_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      pre_q  <= pre_n;
      sel_q  <= sel_n;
      cntb_q <= cntb_n;
      cmpb_q <= cmpb_n;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_RUN]  = ctrl_q.run;
        rd_data[B_AUTO] = ctrl_q.auto_rl;
        rd_data[B_INV]  = ctrl_q.inv;
      end
      A_CLK:  rd_data[CLK_W-1:0] = {sel_q, pre_q};
      A_CNTB: rd_data = cntb_q;
      A_CMPB: rd_data = cmpb_q;
      A_LIVE: rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  pwm_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.run), .pre_i(pre_q), .sel_i(sel_q),
    .tick_o(tick)
  );

  pwm_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .auto_i(ctrl_q.auto_rl), .upd_i(upd),
    .cntb_i(cntb_q), .cmpb_i(cmpb_q), .cnt_o(cnt), .cmp_o(cmp), .irq_o(irq_o)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i(cnt), .cmp_i(cmp), .inv_i(ctrl_q.inv), .pwm_o(pwm_o)
  );

  p_buffer_defers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cntb && !upd && !(tick && cnt == CNT_W'(1))) |=> (cnt != $past(wr_data) || cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));
  p_halt_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (pwm_o == ctrl_q.inv));
endmodule

// File: tb/sim_pwm_timer_top.sv
module sim_pwm_timer_top;
  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        pwm_o, irq_o;
  int cyc, n_chk, n_fail, s;
  int exp_q[$];
  bit done;

  pwm_timer_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o), .irq_o(irq_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string req, input int got, input int expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d", req, got, expv);
    end
  endtask

  // scoreboard monitor: each interrupt must match the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && irq_o) begin
      if (exp_q.size() == 0) chk("R4/R5 unexpected irq cycle", cyc, -1);
      else chk("R4 irq cycle", cyc, exp_q.pop_front());
    end
  end

  task automatic wr_at(input int e, input logic [2:0] a, input logic [15:0] d);
    do @(negedge clk); while (cyc < e - 1);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_at(cyc + 1, a, d);
  endtask

  task automatic rd_at(input int c, input logic [2:0] a, input string req, input int expv);
    do @(negedge clk); while (cyc < c);
    rd_addr = a; #1;
    chk(req, rd_data, expv);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 pwm reset", pwm_o, 0);
    chk("R1 irq reset", irq_o, 0);
    rd_addr = 3'd4; #1 chk("R1 live count reset", rd_data, 0);
    rd_addr = 3'd1; #1 chk("R1 clock cfg reset", rd_data, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // A: T=4 (P=1,D=1), N=5, compare 2, auto-reload, buffer change mid-run
    wr(3'd1, 16'h0101); wr(3'd2, 16'd5); wr(3'd3, 16'd2); wr(3'd0, 16'b0110);
    rd_at(cyc, 3'd4, "R7 manual load count", 5);
    chk("R8 pwm high above compare", pwm_o, 1);
    s = cyc + 2;
    exp_q.push_back(s + 20); exp_q.push_back(s + 40); exp_q.push_back(s + 52);
    wr_at(s, 3'd0, 16'b0011);
    rd_at(s + 9, 3'd4, "R3 count after two ticks", 3);
    chk("R8 pwm high", pwm_o, 1);
    rd_at(s + 13, 3'd4, "R3 count after three ticks", 2);
    chk("R8 pwm low at equal", pwm_o, 0);
    wr_at(s + 25, 3'd2, 16'd3);
    rd_at(s + 30, 3'd4, "R6 period unchanged after buffer write", 3);
    rd_at(s + 31, 3'd2, "R9 count buffer readback", 3);
    wr_at(s + 55, 3'd0, 16'b0010);
    rd_at(s + 70, 3'd4, "R3 hold while stopped", 3);
    chk("R6 new period used", exp_q.size(), 0);

    // B: manual update on the expiry edge, T=1, N=3 then 6
    wr(3'd1, 16'h0000); wr(3'd2, 16'd3); wr(3'd0, 16'b0110);
    s = cyc + 2;
    exp_q.push_back(s + 3); exp_q.push_back(s + 12); exp_q.push_back(s + 18);
    wr_at(s, 3'd0, 16'b0011);
    wr_at(s + 4, 3'd2, 16'd6);
    wr_at(s + 6, 3'd0, 16'b0111);
    rd_at(s + 7, 3'd4, "R7 manual load wins over expiry", 5);
    wr_at(s + 20, 3'd0, 16'b0010);
    rd_at(s + 22, 3'd4, "R3 stopped count", 4);
    rd_at(s + 30, 3'd0, "R9 control readback", 2);
    chk("R7 irq sequence drained", exp_q.size(), 0);

    // C: prescaler only, T=3 (P=2,D=0), N=4
    wr(3'd1, 16'h0002); wr(3'd2, 16'd4); wr(3'd0, 16'b0110);
    s = cyc + 2;
    exp_q.push_back(s + 12); exp_q.push_back(s + 24);
    wr_at(s, 3'd0, 16'b0011);
    rd_at(s + 7, 3'd4, "R2 prescaled tick count", 2);
    wr_at(s + 26, 3'd0, 16'b0010);
    rd_at(s + 28, 3'd1, "R9 clock cfg readback", 2);
    chk("R2 irq sequence drained", exp_q.size(), 0);

    // D: one-shot, divider code 9 clamps to 16, inverted output
    wr(3'd1, 16'h0900); wr(3'd2, 16'd2); wr(3'd3, 16'd0); wr(3'd0, 16'b1100);
    @(negedge clk);
    chk("R8 inverted output before run", pwm_o, 0);
    s = cyc + 2;
    exp_q.push_back(s + 32);
    wr_at(s, 3'd0, 16'b1001);
    rd_at(s + 17, 3'd4, "R2 clamped divider first tick", 1);
    rd_at(s + 40, 3'd4, "R5 one-shot halted at zero", 0);
    chk("R8 inactive level when halted", pwm_o, 1);
    rd_at(s + 140, 3'd4, "R5 still halted", 0);
    chk("R5 single interrupt", exp_q.size(), 0);
    rd_at(s + 141, 3'd0, "R9 control readback inv+run", 9);

    done = 1;
    summary();
  end
endmodule